// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block produces the active-low read and write strobes for one programmed-I/O or multiword DMA cycle on a parallel ATA channel. A single packed 32-bit configuration word carries every duration: separate active (low), recovery (high) and first-cycle setup counts for data transfers and for task-file register accesses. An input picks which of the two sets applies. Every count field stands for its value plus one clock cycles.

A start request that arrives while the block is idle captures the selected counts, the direction and the two status bits from the word. When the caller flags the cycle as the first of a transfer, the block holds both strobes high for the setup interval. It then drives the chosen strobe low for the active time and releases it for the recovery time. One cycle later it raises a single-cycle done pulse and is free again. A cycle that is not the first goes straight to the active phase, so back-to-back cycles carry no setup gap. Two high bits of the word, FIFO enable and bus-master operation during PIO, are reported on status outputs and do not alter the sequence.

Top module: `ata_pio_strobe_gen`

## Requirements
- R1: While reset is applied and afterwards until the first accepted start, rd_n_o and wr_n_o are 1, busy_o and done_o are 0, and fifo_en_o and bus_master_o are 0.
- R2: A start accepted with is_first_i=1 and is_cmd_i=0 makes busy_o rise from the next cycle, with both strobes high for timing_i[24:22]+1 cycles before the active phase.
- R3: A start accepted with is_first_i=1 and is_cmd_i=1 applies a setup interval of timing_i[27:25]+1 cycles instead.
- R4: For a data access (is_cmd_i=0) the selected strobe is low for timing_i[8:4]+1 consecutive cycles.
- R5: For a data access the strobe is then high, with busy_o still 1, for timing_i[3:0]+1 cycles.
- R6: For a task-file access (is_cmd_i=1) the active time is timing_i[17:13]+1 cycles and the recovery time is timing_i[12:9]+1 cycles.
- R7: A start accepted with is_first_i=0 has no setup interval: the strobe goes low in the first busy cycle.
- R8: is_write_i=1 drives only wr_n_o low and is_write_i=0 drives only rd_n_o low; the other strobe stays 1 for the whole cycle, and no strobe is ever low while busy_o is 0.
- R9: A start request while busy_o is 1 is ignored: the running cycle keeps its timing and direction.
- R10: done_o is 1 for exactly one cycle, the cycle right after the recovery phase, in which busy_o is already 0.
- R11: fifo_en_o and bus_master_o show timing_i[31] and timing_i[30] as captured at the last accepted start, and these bits do not change the strobe sequence.
- R12: timing_i, is_write_i, is_cmd_i and is_first_i are sampled only at an accepted start; changes to them during a cycle have no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one strobe cycle |
| is_write_i | input | 1 | 1 selects the write strobe, 0 the read strobe |
| is_cmd_i | input | 1 | 1 selects task-file register timing |
| is_first_i | input | 1 | 1 applies the setup interval before the active phase |
| timing_i | input | 32 | Packed timing configuration word |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-cycle pulse after the recovery phase |
| fifo_en_o | output | 1 | Captured FIFO enable bit |
| bus_master_o | output | 1 | Captured bus-master-during-PIO bit |

## Verification
On every cycle the assertions check that at most one strobe is low, that a low strobe implies busy, that busy only rises after a start request, and that done is a single pulse coinciding with busy falling. The exact lengths of setup, active and recovery phases for each field, the choice between data and task-file counts, the absence of setup on later cycles, and the immunity to mid-cycle input changes are only shown by the bench's scenarios, which predict the full per-cycle waveform from the configuration word and compare it cycle by cycle.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;
  localparam int unsigned WORD_W = 32;

  // field positions in the packed timing word
  localparam int unsigned D_HIGH_LSB = 0;
  localparam int unsigned D_HIGH_MSB = 3;
  localparam int unsigned D_LOW_LSB  = 4;
  localparam int unsigned D_LOW_MSB  = 8;
  localparam int unsigned C_HIGH_LSB = 9;
  localparam int unsigned C_HIGH_MSB = 12;
  localparam int unsigned C_LOW_LSB  = 13;
  localparam int unsigned C_LOW_MSB  = 17;
  localparam int unsigned D_PRE_LSB  = 22;
  localparam int unsigned D_PRE_MSB  = 24;
  localparam int unsigned C_PRE_LSB  = 25;
  localparam int unsigned C_PRE_MSB  = 27;
  localparam int unsigned BM_BIT     = 30;
  localparam int unsigned FIFO_BIT   = 31;

  localparam int unsigned MIN_CNT_W  = 5;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_ACT   = 3'd2,
    PH_REC   = 3'd3,
    PH_END   = 3'd4
  } phase_e;
endpackage

// File: rtl/ata_strobe_decode.sv
module ata_strobe_decode
  import ata_strobe_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic [WORD_W-1:0] timing_i,
  input  logic              is_cmd_i,
  output logic [CNT_W-1:0]  pre_len_o,
  output logic [CNT_W-1:0]  act_len_o,
  output logic [CNT_W-1:0]  rec_len_o,
  output logic              fifo_o,
  output logic              bm_o
);
  logic [CNT_W-1:0] d_pre, d_act, d_rec, c_pre, c_act, c_rec;

  assign d_pre = CNT_W'(timing_i[D_PRE_MSB:D_PRE_LSB]);
  assign d_act = CNT_W'(timing_i[D_LOW_MSB:D_LOW_LSB]);
  assign d_rec = CNT_W'(timing_i[D_HIGH_MSB:D_HIGH_LSB]);
  assign c_pre = CNT_W'(timing_i[C_PRE_MSB:C_PRE_LSB]);
  assign c_act = CNT_W'(timing_i[C_LOW_MSB:C_LOW_LSB]);
  assign c_rec = CNT_W'(timing_i[C_HIGH_MSB:C_HIGH_LSB]);

  always_comb begin
    if (is_cmd_i) begin
      pre_len_o = c_pre;
      act_len_o = c_act;
      rec_len_o = c_rec;
    end else begin
      pre_len_o = d_pre;
      act_len_o = d_act;
      rec_len_o = d_rec;
    end
  end

  assign fifo_o = timing_i[FIFO_BIT];
  assign bm_o   = timing_i[BM_BIT];

  // bits 21:18 and 29:28 belong to modes this block does not drive
  logic unused_fields;
  assign unused_fields = ^{timing_i[21:18], timing_i[29:28]};
endmodule

// File: rtl/ata_strobe_seq.sv
module ata_strobe_seq
  import ata_strobe_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             is_write_i,
  input  logic             is_first_i,
  input  logic [CNT_W-1:0] pre_len_i,
  input  logic [CNT_W-1:0] act_len_i,
  input  logic [CNT_W-1:0] rec_len_i,
  output phase_e           phase_o,
  output logic             write_o,
  output logic             accept_o
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] act_q, rec_q;
  logic             wr_q;
  logic             idle;
  logic             last;

  assign idle     = (phase_q == PH_IDLE) || (phase_q == PH_END);
  assign accept_o = start_i && idle;
  assign last     = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_SETUP: begin
        if (last) begin
          phase_d = PH_ACT;
          cnt_d   = act_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_ACT: begin
        if (last) begin
          phase_d = PH_REC;
          cnt_d   = rec_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_REC: begin
        if (last) phase_d = PH_END;
        else      cnt_d   = cnt_q - 1'b1;
      end
      PH_END:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
    if (accept_o) begin
      phase_d = is_first_i ? PH_SETUP : PH_ACT;
      cnt_d   = is_first_i ? pre_len_i : act_len_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      act_q   <= '0;
      rec_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (accept_o) begin
        act_q <= act_len_i;
        rec_q <= rec_len_i;
        wr_q  <= is_write_i;
      end
    end
  end

  assign phase_o = phase_q;
  assign write_o = wr_q;
endmodule

// File: rtl/ata_strobe_drive.sv
module ata_strobe_drive
  import ata_strobe_pkg::*;
(
  input  phase_e phase_i,
  input  logic   write_i,
  output logic   rd_n_o,
  output logic   wr_n_o,
  output logic   busy_o,
  output logic   done_o
);
  logic active;

  assign active = (phase_i == PH_ACT);
  assign rd_n_o = !(active && !write_i);
  assign wr_n_o = !(active && write_i);
  assign busy_o = (phase_i == PH_SETUP) || (phase_i == PH_ACT) || (phase_i == PH_REC);
  assign done_o = (phase_i == PH_END);
endmodule

// File: rtl/ata_pio_strobe_gen.sv
module ata_pio_strobe_gen
  import ata_strobe_pkg::*;
#(
  parameter int unsigned CNT_W = MIN_CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              is_write_i,
  input  logic              is_cmd_i,
  input  logic              is_first_i,
  input  logic [WORD_W-1:0] timing_i,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fifo_en_o,
  output logic              bus_master_o
);
  logic [CNT_W-1:0] pre_len, act_len, rec_len;
  logic             fifo_w, bm_w;
  phase_e           phase;
  logic             write_sel;
  logic             accept;
  logic             fifo_q, bm_q;

  ata_strobe_decode #(.CNT_W(CNT_W)) i_decode (
    .timing_i  (timing_i),
    .is_cmd_i  (is_cmd_i),
    .pre_len_o (pre_len),
    .act_len_o (act_len),
    .rec_len_o (rec_len),
    .fifo_o    (fifo_w),
    .bm_o      (bm_w)
  );

  ata_strobe_seq #(.CNT_W(CNT_W)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .is_write_i (is_write_i),
    .is_first_i (is_first_i),
    .pre_len_i  (pre_len),
    .act_len_i  (act_len),
    .rec_len_i  (rec_len),
    .phase_o    (phase),
    .write_o    (write_sel),
    .accept_o   (accept)
  );

  ata_strobe_drive i_drive (
    .phase_i (phase),
    .write_i (write_sel),
    .rd_n_o  (rd_n_o),
    .wr_n_o  (wr_n_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_q <= 1'b0;
      bm_q   <= 1'b0;
    end else if (accept) begin
      fifo_q <= fifo_w;
      bm_q   <= bm_w;
    end
  end

  assign fifo_en_o    = fifo_q;
  assign bus_master_o = bm_q;
endmodule

// File: rtl/ata_pio_strobe_chk.sv
module ata_pio_strobe_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic rd_n_o,
  input logic wr_n_o,
  input logic busy_o,
  input logic done_o
);
  a_r8_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_n_o || wr_n_o);

  a_r8_strobe_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o) |-> busy_o);

  a_r9_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r10_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind ata_pio_strobe_gen ata_pio_strobe_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .rd_n_o (rd_n_o),
  .wr_n_o (wr_n_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/test_ata_pio_strobe_gen.sv
module test_ata_pio_strobe_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        is_write_i = 1'b0;
  logic        is_cmd_i = 1'b0;
  logic        is_first_i = 1'b0;
  logic [31:0] timing_i = '0;
  logic        rd_n_o, wr_n_o, busy_o, done_o, fifo_en_o, bus_master_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic exp_fifo = 1'b0;
  logic exp_bm = 1'b0;

  typedef struct packed {
    logic rd_n;
    logic wr_n;
    logic busy;
    logic done;
    logic fifo;
    logic bm;
  } obs_t;

  typedef struct {
    obs_t  val;
    string tag;
  } item_t;

  item_t sb_q[$];

  ata_pio_strobe_gen i_ata_pio_strobe_gen (
    .clk_i, .rst_ni, .start_i, .is_write_i, .is_cmd_i, .is_first_i,
    .timing_i, .rd_n_o, .wr_n_o, .busy_o, .done_o, .fifo_en_o, .bus_master_o
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [31:0] mk(logic f, logic bm, int cpre, int dpre,
                                     int clow, int chigh, int dlow, int dhigh);
    logic [31:0] w;
    w = '0;
    w[31] = f; w[30] = bm;
    w[27:25] = 3'(cpre); w[24:22] = 3'(dpre);
    w[17:13] = 5'(clow); w[12:9] = 4'(chigh);
    w[8:4] = 5'(dlow);   w[3:0] = 4'(dhigh);
    w[21:18] = 4'hA; w[29:28] = 2'b11;  // bits outside this block's scope
    return w;
  endfunction

  function automatic obs_t sample();
    return '{rd_n_o, wr_n_o, busy_o, done_o, fifo_en_o, bus_master_o};
  endfunction

  task automatic check(string tag, obs_t act, obs_t exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual rd_n,wr_n,busy,done,fifo,bm=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per cycle, otherwise expects idle
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (sb_q.size() != 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, sample(), it.val);
      end else begin
        check("R1/R10 idle", sample(), '{1'b1, 1'b1, 1'b0, 1'b0, exp_fifo, exp_bm});
      end
    end
  end

  // driver: issue one cycle and push its expected waveform
  task automatic run(string tag, logic wr, logic cmd, logic first, logic [31:0] w,
                     bit disturb);
    int pre, act, rec;
    @(negedge clk_i);
    start_i = 1'b1; is_write_i = wr; is_cmd_i = cmd; is_first_i = first; timing_i = w;
    pre = first ? (cmd ? int'(w[27:25]) : int'(w[24:22])) + 1 : 0;
    act = (cmd ? int'(w[17:13]) : int'(w[8:4])) + 1;
    rec = (cmd ? int'(w[12:9]) : int'(w[3:0])) + 1;
    @(posedge clk_i);
    #1;
    start_i = 1'b0;
    exp_fifo = w[31]; exp_bm = w[30];
    for (int i = 0; i < pre; i++)
      sb_q.push_back('{'{1'b1, 1'b1, 1'b1, 1'b0, w[31], w[30]}, {tag, " setup R2/R3"}});
    for (int i = 0; i < act; i++)
      sb_q.push_back('{'{wr, ~wr, 1'b1, 1'b0, w[31], w[30]}, {tag, " active R4/R6/R7/R8"}});
    for (int i = 0; i < rec; i++)
      sb_q.push_back('{'{1'b1, 1'b1, 1'b1, 1'b0, w[31], w[30]}, {tag, " recovery R5/R6"}});
    sb_q.push_back('{'{1'b1, 1'b1, 1'b0, 1'b1, w[31], w[30]}, {tag, " done R10"}});
    if (disturb) begin
      // R9 R12: new request and changed inputs while busy
      @(negedge clk_i);
      start_i = 1'b1; is_write_i = ~wr; is_cmd_i = ~cmd; is_first_i = ~first;
      timing_i = ~w;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (sb_q.size() != 0) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 in reset", sample(), '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0});
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    run("R2 R4 R5 data read first",  1'b0, 1'b0, 1'b1, mk(0, 0, 5, 2, 6, 7, 3, 1), 1'b0);
    run("R7 data write not first",   1'b1, 1'b0, 1'b0, mk(0, 0, 5, 2, 6, 7, 4, 2), 1'b0);
    run("R3 R6 cmd read first",      1'b0, 1'b1, 1'b1, mk(0, 0, 4, 1, 5, 2, 9, 9), 1'b0);
    run("R6 R7 cmd write not first", 1'b1, 1'b1, 1'b0, mk(0, 0, 4, 1, 3, 0, 9, 9), 1'b0);
    run("R4 R5 min fields",          1'b1, 1'b0, 1'b1, mk(0, 0, 7, 0, 9, 9, 0, 0), 1'b0);
    run("R2 R4 R5 max data fields",  1'b0, 1'b0, 1'b1, mk(0, 0, 0, 7, 0, 0, 31, 15), 1'b0);
    run("R3 R6 max cmd fields",      1'b1, 1'b1, 1'b1, mk(0, 0, 7, 0, 31, 15, 0, 0), 1'b0);
    run("R11 fifo and bm set",       1'b0, 1'b0, 1'b1, mk(1, 1, 2, 3, 2, 2, 2, 2), 1'b0);
    run("R11 fifo only",             1'b1, 1'b0, 1'b0, mk(1, 0, 2, 3, 2, 2, 2, 2), 1'b0);
    run("R9 R12 start while busy",   1'b0, 1'b0, 1'b1, mk(0, 1, 1, 1, 1, 1, 3, 2), 1'b1);
    run("R9 R12 busy min length",    1'b1, 1'b1, 1'b0, mk(1, 0, 0, 0, 0, 0, 0, 0), 1'b1);
    repeat (4) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // watchdog
  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=20000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule